// File: doc/BRIEF.md
# Receive Label Filter with Parity Gate

This block sits between the word assembler of a serial avionics receiver and its 32-word receive FIFO. Each completed 32-bit word is screened once. The optional odd-parity test comes first. The 8-bit label in bits 7..0 may then be bit-reversed. Finally, the label can be looked up in a 256-entry acceptance table. A word that passes all the stages in force is offered to the FIFO as a single-cycle push.

The host drives four control inputs. One enables label recognition. One selects the label bit order. One bypasses the parity test so that all 32 bits pass through as data. The table is written one entry per cycle through a write port. When parity checking is on, bit 31 of a stored word no longer carries the parity bit. It holds a parity-error flag, which is always 0 because words that fail the test are discarded. If the FIFO reports full when a push is due, the word is lost and a sticky overflow flag is raised.

Top module: `labelFilter`

## Requirements
- R1: After reset, pushValid and overflowFlag are 0 and every acceptance table entry is 0, so with recognition enabled no word is pushed until an entry is written.
- R2: With parityOff low, a word whose 32 bits hold an even number of ones is never pushed.
- R3: With parityOff low, an accepted word is pushed with bit 31 forced to 0 and bits 30..8 unchanged.
- R4: With parityOff high, words of either parity are accepted and bits 31..8 are pushed unchanged.
- R5: With recogEn low, every word that passes the parity stage is pushed, whatever the table contents.
- R6: With recogEn high, a word is pushed only if the table entry indexed by its effective label is 1. Asserting tblWrEn for one cycle sets the entry at tblWrAddr to tblWrData.
- R7: With labelRev high, the effective label is word bits 7..0 reversed, so word bit i lands at label position 7-i. The reversed label is used both for the table lookup and as pushData[7:0]. With labelRev low, the label is bits 7..0 as they are.
- R8: A word presented with wordValid in cycle n produces pushValid in cycle n+1 for one cycle only, with pushData valid in that cycle. recogEn, labelRev and parityOff are sampled in cycle n. A table write in cycle n does not affect the word presented in cycle n.
- R9: If fifoFull is high in the cycle a push is due, pushValid stays 0, the word is dropped, and overflowFlag is 1 from the following cycle.
- R10: overflowFlag, once set, stays 1 until reset, and later words are still pushed normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | A completed word is present on wordIn |
| wordIn | input | 32 | Received word, label in bits 7..0 |
| recogEn | input | 1 | Enable label acceptance table |
| labelRev | input | 1 | Reverse label bit order |
| parityOff | input | 1 | Bypass odd-parity check, keep bit 31 |
| tblWrEn | input | 1 | Write one table entry |
| tblWrAddr | input | 8 | Table entry index |
| tblWrData | input | 1 | Value written to the entry |
| fifoFull | input | 1 | Receive FIFO cannot take a push |
| pushValid | output | 1 | Push strobe toward the FIFO |
| pushData | output | 32 | Word to be stored |
| overflowFlag | output | 1 | Sticky: an accepted word was dropped |

## Verification
The push decision and pushData are due one cycle after the cycle that carries wordValid. The bench drives stimulus on the falling edge and samples pushValid and pushData on the next falling edge, after exactly one rising edge. overflowFlag trails pushValid by one more register, so it is sampled one falling edge later, and the same sample also confirms that pushValid has dropped back to 0. For the test of a write and a word in the same cycle, the bench applies both on the same falling edge and expects the old entry to decide the result.

// File: rtl/lblFilterPkg.sv
package lblFilterPkg;
  // Strobes sent from the control unit to the datapath
  typedef struct packed {
    logic loadWord;   // capture the formatted word for the next push
  } ctrlStrobes_t;
endpackage

// File: rtl/labelTable.sv
module labelTable #(
  parameter int LABEL_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [LABEL_W-1:0] wrAddr,
  input  logic               wrData,
  input  logic [LABEL_W-1:0] rdAddr,
  output logic               rdHit
);
  localparam int DEPTH = 1 << LABEL_W;

  logic [DEPTH-1:0] entries;

  always_ff @(posedge clk) begin
    if (!rstN)     entries <= '0;
    else if (wrEn) entries[wrAddr] <= wrData;
  end

  // Lookup reads the entry as it was before any write on this edge
  assign rdHit = entries[rdAddr];
endmodule

// File: rtl/wordDatapath.sv
module wordDatapath
  import lblFilterPkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int LABEL_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WORD_W-1:0]  wordIn,
  input  logic               labelRev,
  input  logic               parityOff,
  input  ctrlStrobes_t       strobes,
  output logic [LABEL_W-1:0] effLabel,
  output logic               parityOk,
  output logic [WORD_W-1:0]  storedWord
);
  localparam int MID_W = WORD_W - 1 - LABEL_W;

  logic [LABEL_W-1:0] revLabel;
  logic [WORD_W-1:0]  formatted;
  logic               topBit;

  for (genvar i = 0; i < LABEL_W; i++) begin : g_rev
    assign revLabel[i] = wordIn[LABEL_W-1-i];
  end

  assign effLabel  = labelRev ? revLabel : wordIn[LABEL_W-1:0];
  assign parityOk  = ^wordIn;
  // Checked words carry a clear error flag in the top bit
  assign topBit    = parityOff ? wordIn[WORD_W-1] : 1'b0;
  assign formatted = {topBit, wordIn[WORD_W-2 -: MID_W], effLabel};

  always_ff @(posedge clk) begin
    if (!rstN)                 storedWord <= '0;
    else if (strobes.loadWord) storedWord <= formatted;
  end
endmodule

// File: rtl/filterCtrl.sv
module filterCtrl
  import lblFilterPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wordValid,
  input  logic         parityOk,
  input  logic         labelHit,
  input  logic         recogEn,
  input  logic         parityOff,
  input  logic         fifoFull,
  output ctrlStrobes_t strobes,
  output logic         pushValid,
  output logic         overflowFlag
);
  logic parityPass;
  logic labelPass;
  logic accept;
  logic pendingPush;

  assign parityPass = parityOff | parityOk;
  assign labelPass  = ~recogEn | labelHit;
  assign accept     = wordValid & parityPass & labelPass;

  assign strobes.loadWord = accept;

  always_ff @(posedge clk) begin
    if (!rstN) pendingPush <= 1'b0;
    else       pendingPush <= accept;
  end

  assign pushValid = pendingPush & ~fifoFull;

  always_ff @(posedge clk) begin
    if (!rstN)                        overflowFlag <= 1'b0;
    else if (pendingPush && fifoFull) overflowFlag <= 1'b1;
  end

  p_push_after_word_r8: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> $past(wordValid));
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);
  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflowFlag) |-> $past(fifoFull));
endmodule

// File: rtl/labelFilter.sv
module labelFilter
  import lblFilterPkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int LABEL_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wordValid,
  input  logic [WORD_W-1:0]  wordIn,
  input  logic               recogEn,
  input  logic               labelRev,
  input  logic               parityOff,
  input  logic               tblWrEn,
  input  logic [LABEL_W-1:0] tblWrAddr,
  input  logic               tblWrData,
  input  logic               fifoFull,
  output logic               pushValid,
  output logic [WORD_W-1:0]  pushData,
  output logic               overflowFlag
);
  ctrlStrobes_t       strobes;
  logic [LABEL_W-1:0] effLabel;
  logic               parityOk;
  logic               labelHit;

  labelTable #(.LABEL_W(LABEL_W)) uTable (
    .clk(clk), .rstN(rstN),
    .wrEn(tblWrEn), .wrAddr(tblWrAddr), .wrData(tblWrData),
    .rdAddr(effLabel), .rdHit(labelHit)
  );

  wordDatapath #(.WORD_W(WORD_W), .LABEL_W(LABEL_W)) uPath (
    .clk(clk), .rstN(rstN), .wordIn(wordIn),
    .labelRev(labelRev), .parityOff(parityOff), .strobes(strobes),
    .effLabel(effLabel), .parityOk(parityOk), .storedWord(pushData)
  );

  filterCtrl uCtrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid),
    .parityOk(parityOk), .labelHit(labelHit),
    .recogEn(recogEn), .parityOff(parityOff), .fifoFull(fifoFull),
    .strobes(strobes), .pushValid(pushValid), .overflowFlag(overflowFlag)
  );

  p_parity_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> ($past(parityOff) || (^$past(wordIn))));
  p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !$past(parityOff)) |-> !pushData[WORD_W-1]);
endmodule

// File: tb/tb_labelFilter.sv
`timescale 1ns/1ps
module tb_labelFilter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [31:0] wordIn = '0;
  logic        recogEn = 1'b0;
  logic        labelRev = 1'b0;
  logic        parityOff = 1'b0;
  logic        tblWrEn = 1'b0;
  logic [7:0]  tblWrAddr = '0;
  logic        tblWrData = 1'b0;
  logic        fifoFull = 1'b0;
  logic        pushValid;
  logic [31:0] pushData;
  logic        overflowFlag;

  int checks = 0;
  int errors = 0;
  logic [255:0] model = '0;
  logic ovfModel = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  labelFilter dut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .recogEn(recogEn), .labelRev(labelRev), .parityOff(parityOff),
    .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr), .tblWrData(tblWrData),
    .fifoFull(fifoFull), .pushValid(pushValid), .pushData(pushData),
    .overflowFlag(overflowFlag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] revByte(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [31:0] mkWord(input logic [7:0] lab, input logic [22:0] data, input bit odd);
    logic [31:0] w;
    w = {1'b0, data, lab};
    if ((^w) != odd) w[31] = 1'b1;
    return w;
  endfunction

  task automatic writeEntry(input logic [7:0] a, input logic v);
    @(negedge clk); tblWrEn = 1'b1; tblWrAddr = a; tblWrData = v;
    @(negedge clk); tblWrEn = 1'b0;
    model[a] = v;
  endtask

  task automatic sendWord(input logic [31:0] w, input string req);
    logic [7:0]  lab;
    logic        expAcc;
    logic        expPush;
    logic [31:0] expData;
    lab     = labelRev ? revByte(w[7:0]) : w[7:0];
    expAcc  = (parityOff || (^w)) && (!recogEn || model[lab]);
    expPush = expAcc && !fifoFull;
    expData = {parityOff ? w[31] : 1'b0, w[30:8], lab};
    @(negedge clk); wordValid = 1'b1; wordIn = w;
    @(negedge clk); wordValid = 1'b0;
    chk(pushValid == expPush, req, {31'b0, pushValid}, {31'b0, expPush});
    if (expPush) chk(pushData == expData, req, pushData, expData);
    if (expAcc && fifoFull) ovfModel = 1'b1;
    @(negedge clk);
    chk(pushValid == 1'b0, "R8", {31'b0, pushValid}, 32'd0);
    chk(overflowFlag == ovfModel, (expAcc && fifoFull) ? "R9" : "R10",
        {31'b0, overflowFlag}, {31'b0, ovfModel});
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R8: watchdog expired actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(pushValid == 1'b0, "R1", {31'b0, pushValid}, 32'd0);
    chk(overflowFlag == 1'b0, "R1", {31'b0, overflowFlag}, 32'd0);

    // R1: empty table rejects every label with recognition on
    recogEn = 1'b1;
    for (int l = 0; l < 256; l++) sendWord(mkWord(8'(l), 23'(l * 113), 1'b1), "R1");

    // R6: programmed table, including one entry cleared again
    for (int l = 0; l < 256; l += 3) writeEntry(8'(l), 1'b1);
    writeEntry(8'd9, 1'b0);
    for (int l = 0; l < 256; l++) sendWord(mkWord(8'(l), 23'(l * 7 + 5), 1'b1), "R6");

    // R7: reversed label order for lookup and stored label
    labelRev = 1'b1;
    for (int l = 0; l < 256; l++) sendWord(mkWord(8'(l), 23'(l * 29), 1'b1), "R7");
    labelRev = 1'b0;

    // R5: recognition off accepts every label with good parity
    recogEn = 1'b0;
    for (int l = 0; l < 256; l++) sendWord(mkWord(8'(l), 23'(l * 331), 1'b1), "R5");

    // R2 / R3: parity gate and top-bit flag under varied data
    for (int k = 0; k < 64; k++) begin
      sendWord(mkWord(8'(k * 5), 23'(k * 130817), 1'b1), "R3");
      sendWord(mkWord(8'(k * 5), 23'(k * 130817), 1'b0), "R2");
    end
    recogEn = 1'b1;
    for (int k = 0; k < 32; k++) sendWord(mkWord(8'(k * 3), 23'(k * 999), 1'b0), "R2");

    // R4: parity bypass keeps all bits, either parity
    parityOff = 1'b1;
    recogEn = 1'b0;
    for (int k = 0; k < 64; k++) begin
      sendWord(mkWord(8'(k * 9), 23'(k * 54321), 1'b1), "R4");
      sendWord(mkWord(8'(k * 9), 23'(k * 54321), 1'b0), "R4");
    end
    labelRev = 1'b1;
    recogEn = 1'b1;
    for (int k = 0; k < 16; k++) sendWord(mkWord(8'(k * 17), 23'(k * 77), 1'b0), "R4");
    labelRev = 1'b0;
    parityOff = 1'b0;

    // R8: table write in the same cycle as the word is not seen by it
    @(negedge clk);
    tblWrEn = 1'b1; tblWrAddr = 8'd1; tblWrData = 1'b1;
    wordValid = 1'b1; wordIn = mkWord(8'd1, 23'h1234, 1'b1);
    @(negedge clk);
    tblWrEn = 1'b0; wordValid = 1'b0;
    chk(pushValid == 1'b0, "R8", {31'b0, pushValid}, 32'd0);
    model[1] = 1'b1;
    @(negedge clk);
    sendWord(mkWord(8'd1, 23'h1234, 1'b1), "R8");

    // R9 / R10: drop on full, sticky flag, normal pushes afterwards
    fifoFull = 1'b1;
    sendWord(mkWord(8'd3, 23'h55AA, 1'b1), "R9");
    sendWord(mkWord(8'd2, 23'h55AA, 1'b1), "R9");
    fifoFull = 1'b0;
    sendWord(mkWord(8'd6, 23'h0F0F, 1'b1), "R10");
    sendWord(mkWord(8'd12, 23'h7FFFFF, 1'b1), "R10");
    repeat (3) @(negedge clk);
    chk(overflowFlag == 1'b1, "R10", {31'b0, overflowFlag}, 32'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule